// File: doc/BRIEF.md
# Paced Tester-Cycle Sequencer

This block divides the fast system clock into slower tester cycles and feeds one pattern word into each of them. A programmable divider N sets the length of a tester cycle in system clocks. A down-counter runs from N-1 to 0 inside every cycle, so downstream edge-placement logic can compare against it to put transitions at chosen points. At the start of each tester cycle the block takes exactly one word from an upstream first-word-fall-through FIFO and holds it in a register for the whole cycle.

A run begins with a start pulse that samples the divider and the number of cycles to play. From then on, two things pace the sequencer. If no word is waiting when a new cycle needs one, the counter freezes at zero and a sticky underrun flag is set. Once the programmed number of cycles has played out, the block returns to idle. The FIFO handshake itself decides whether a word is available: the word is consumed in the clock where read and valid are both high. No separately sampled fill level is used.

Top module: `cycle_pacer`

## Requirements
- R1: With an effective divider N, the count output steps down by one per clock from N-1 to 0, and consecutive tester cycles start exactly N clocks apart when no stall occurs.
- R2: The cycle strobe is high for exactly one clock at the start of every tester cycle. It rises in the clock after the word is read, and in that clock the count output equals N-1.
- R3: The FIFO is read exactly once per tester cycle, and only while the count output is 0. The word output takes the read word together with the strobe and holds it unchanged until the next read.
- R4: Before a start, no FIFO read, strobe or count change occurs. A start pulse is ignored while a run is active, and it is also ignored when the requested cycle count is 0.
- R5: A run with a cycle count of C reads exactly C words. When the last cycle's count reaches 0, the running output clears in the next clock, and the count stays at 0 with no further reads, even if words remain in the FIFO.
- R6: If a word is due but the FIFO valid input is low, the block performs no read, keeps the count at 0 and raises no strobe. It resumes on the first clock in which valid is high.
- R7: The divider input is sampled only when a run starts, and later changes have no effect on that run. Divider values 0 and 1 behave as N = 2.
- R8: An active-low asynchronous reset clears the count, the running output, the strobe, the word output and the underrun flag.
- R9: The underrun output becomes 1 in the clock after any stall. It stays 1 until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-clock request to begin a run |
| div_i | input | DIV_W | Divider N, system clocks per tester cycle |
| cycles_i | input | CNT_W | Number of tester cycles in the run |
| fifo_valid_i | input | 1 | FIFO holds a word on fifo_data_i |
| fifo_data_i | input | WORD_W | Word at the FIFO head |
| fifo_rd_o | output | 1 | Pops the FIFO head in this clock |
| word_o | output | WORD_W | Registered pattern word for the current tester cycle |
| cyc_stb_o | output | 1 | One-clock strobe at the start of each tester cycle |
| count_o | output | DIV_W | Position within the tester cycle, N-1 down to 0 |
| running_o | output | 1 | A run is in progress |
| underrun_o | output | 1 | Sticky: a word was due while the FIFO was empty |

## Verification
On every clock, the assertions check the following local rules:
- the counter reloads after a read, steps down by one and freezes during a stall;
- the strobe lasts a single clock;
- the word register is stable between reads;
- reads never happen while idle or at a nonzero count;
- the completed-cycle tally never passes the programmed total;
- the underrun flag stays set.

Some properties span a whole run, and only the bench's directed scenarios can show them: the exact spacing of strobes, the sequence and number of words consumed, the clock on which running drops, the effect of clamping, and that starts and divider changes during a run are ignored. The stall scenario then shows that a late word restarts the cycle one clock after valid rises.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // What the sequencer does in the current clock.
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,  // no run active
    ACT_COUNT = 3'd1,  // count steps down inside a cycle
    ACT_TAKE  = 3'd2,  // word consumed, new cycle begins
    ACT_STALL = 3'd3,  // word due but FIFO empty
    ACT_END   = 3'd4   // last cycle finished
  } act_e;

endpackage

// File: rtl/pacer_divider.sv
module pacer_divider
  import pacer_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  act_e             act_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             zero_o
);

  localparam logic [DIV_W-1:0] MIN_RELOAD = DIV_W'(1);
  localparam logic [DIV_W-1:0] MIN_DIV    = DIV_W'(2);

  logic [DIV_W-1:0] reload_q, reload_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Divider sampled only at start; values below 2 clamp to a reload of 1.
  always_comb begin
    reload_d = reload_q;
    if (load_i) begin
      reload_d = (div_i < MIN_DIV) ? MIN_RELOAD : (div_i - DIV_W'(1));
    end
  end

  always_comb begin
    cnt_en = load_i || (act_i == ACT_TAKE) || (act_i == ACT_COUNT);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = '0;
    end else begin
      unique case (act_i)
        ACT_TAKE:  cnt_d = reload_q;
        ACT_COUNT: cnt_d = cnt_q - DIV_W'(1);
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= MIN_RELOAD;
    end else if (load_i) begin
      reload_q <= reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_RELOAD_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_TAKE) |=> (cnt_q == reload_q)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_COUNT) |=> (cnt_q == $past(cnt_q) - DIV_W'(1))); // R1
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STALL) |=> (cnt_q == '0)); // R6
  AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(reload_q)); // R7
  AST_RELOAD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q >= MIN_RELOAD); // R7

endmodule

// File: rtl/pacer_tally.sv
module pacer_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             take_i,
  output logic             more_o
);

  logic [CNT_W-1:0] done_q, done_d;
  logic [CNT_W-1:0] total_q;
  logic             done_en;

  always_comb begin
    done_en = load_i || take_i;
    done_d  = load_i ? '0 : (done_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
    end else if (load_i) begin
      total_q <= cycles_i;
    end
  end

  assign more_o = (done_q != total_q);

  AST_DONE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q <= total_q); // R5
  AST_TAKE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !load_i) |=> (done_q == $past(done_q) + CNT_W'(1))); // R5

endmodule

// File: rtl/pacer_word.sv
module pacer_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              stb_o
);

  logic [WORD_W-1:0] word_q;
  logic              stb_q, stb_d;

  assign stb_d = take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (take_i) begin
      word_q <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(word_q)); // R3
  AST_STB_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> stb_q); // R2

endmodule

// File: rtl/cycle_pacer.sv
module cycle_pacer
  import pacer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  cycles_i,
  input  logic              fifo_valid_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic [WORD_W-1:0] word_o,
  output logic              cyc_stb_o,
  output logic [DIV_W-1:0]  count_o,
  output logic              running_o,
  output logic              underrun_o
);

  logic running_q, running_d;
  logic undr_q, undr_d;
  logic start_ok;
  logic zero, more, take;
  act_e act;

  assign start_ok = start_i && !running_q && (cycles_i != '0);

  // Decide this clock's action from run state, counter and FIFO handshake.
  always_comb begin
    if (!running_q) begin
      act = ACT_IDLE;
    end else if (!zero) begin
      act = ACT_COUNT;
    end else if (!more) begin
      act = ACT_END;
    end else if (fifo_valid_i) begin
      act = ACT_TAKE;
    end else begin
      act = ACT_STALL;
    end
  end

  assign take      = (act == ACT_TAKE);
  assign fifo_rd_o = take;

  always_comb begin
    running_d = running_q;
    if (start_ok) begin
      running_d = 1'b1;
    end else if (act == ACT_END) begin
      running_d = 1'b0;
    end
  end

  always_comb begin
    undr_d = undr_q;
    if (start_ok) begin
      undr_d = 1'b0;
    end else if (act == ACT_STALL) begin
      undr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      undr_q    <= 1'b0;
    end else begin
      running_q <= running_d;
      undr_q    <= undr_d;
    end
  end

  pacer_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_ok),
    .div_i  (div_i),
    .act_i  (act),
    .cnt_o  (count_o),
    .zero_o (zero)
  );

  pacer_tally #(.CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_ok),
    .cycles_i (cycles_i),
    .take_i   (take),
    .more_o   (more)
  );

  pacer_word #(.WORD_W(WORD_W)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .data_i (fifo_data_i),
    .word_o (word_o),
    .stb_o  (cyc_stb_o)
  );

  assign running_o  = running_q;
  assign underrun_o = undr_q;

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !fifo_rd_o); // R4
  AST_READ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> (count_o == '0)); // R3
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb_o |=> !cyc_stb_o); // R2
  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (count_o == '0)); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !start_i) |=> underrun_o); // R9
  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !fifo_valid_i) |-> !fifo_rd_o); // R6

endmodule

// File: tb/cycle_pacer_test.sv
module cycle_pacer_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int DIV_W  = 8;
  localparam int CNT_W  = 16;
  localparam logic [31:0] TAG = 32'hC0DE_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [DIV_W-1:0]  div_i;
  logic [CNT_W-1:0]  cycles_i;
  logic              fifo_valid;
  logic [WORD_W-1:0] fifo_data;
  logic              fifo_rd;
  logic [WORD_W-1:0] word_o;
  logic              cyc_stb_o;
  logic [DIV_W-1:0]  count_o;
  logic              running_o;
  logic              underrun_o;

  int checks = 0;
  int fails  = 0;
  int clocks = 0;

  // FIFO model: word at position p holds TAG + p.
  logic [31:0] mem [0:255];
  int wr_cnt = 0;
  int rd_ptr = 0;

  assign fifo_valid = (wr_cnt > rd_ptr);
  assign fifo_data  = mem[rd_ptr % 256];

  always @(posedge clk) begin
    if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  cycle_pacer #(.WORD_W(WORD_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .div_i        (div_i),
    .cycles_i     (cycles_i),
    .fifo_valid_i (fifo_valid),
    .fifo_data_i  (fifo_data),
    .fifo_rd_o    (fifo_rd),
    .word_o       (word_o),
    .cyc_stb_o    (cyc_stb_o),
    .count_o      (count_o),
    .running_o    (running_o),
    .underrun_o   (underrun_o)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    clocks <= clocks + 1;
    if (clocks > 50000) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired: actual %0d clocks, expected below 50000", clocks);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int n);
    for (int k = 0; k < n; k++) begin
      mem[wr_cnt % 256] = TAG + wr_cnt;
      wr_cnt++;
    end
  endtask

  task automatic flush();
    wr_cnt = rd_ptr;
  endtask

  task automatic do_start(input int dv, input int cy);
    @(negedge clk);
    div_i = DIV_W'(dv);
    cycles_i = CNT_W'(cy);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Watches a run from the negedge after the start edge (index 0).
  task automatic watch(input int n, input int restart_at, input int pos0,
                       output int strobes, output int end_idx, output int bad_cnt,
                       output int bad_word, output int bad_gap, output int bad_step);
    int last = 0;
    logic [DIV_W-1:0] pc = '0;
    logic [31:0] pw = '0;
    strobes = 0; end_idx = -1; bad_cnt = 0; bad_word = 0; bad_gap = 0; bad_step = 0;
    for (int i = 0; i < 400; i++) begin
      if (i > 0) @(negedge clk);
      start_i = (i == restart_at);
      if (i == restart_at) begin
        cycles_i = CNT_W'(9);
        div_i = DIV_W'(7);
      end
      if (i == 1) div_i = DIV_W'(15);  // R7: ignored mid-run
      if (!running_o) begin
        end_idx = i;
        break;
      end
      if (cyc_stb_o) begin
        if (count_o != DIV_W'(n - 1)) bad_cnt++;
        if (word_o != TAG + pos0 + strobes) bad_word++;
        if (strobes == 0 && i != 1) bad_gap++;
        if (strobes > 0 && (i - last) != n) bad_gap++;
        last = i;
        strobes++;
      end else if (i > 1) begin
        if (count_o != pc - DIV_W'(1)) bad_step++;
        if (word_o != pw) bad_word++;
      end
      pc = count_o;
      pw = word_o;
    end
    start_i = 1'b0;
  endtask

  task automatic run_plain(input string tag, input int dv, input int n, input int cy,
                           input int restart_at);
    int s, e, bc, bw, bg, bs, pos0;
    flush();
    push(cy + 2);
    pos0 = rd_ptr;
    do_start(dv, cy);
    chk(underrun_o == 1'b0, "R9", {tag, " underrun clear at start"}, underrun_o, 0);
    watch(n, restart_at, pos0, s, e, bc, bw, bg, bs);
    chk(s == cy, "R3", {tag, " strobes per run"}, s, cy);
    chk(rd_ptr - pos0 == cy, "R3", {tag, " words read"}, rd_ptr - pos0, cy);
    chk(e == 1 + cy * n, "R5", {tag, " running clears"}, e, 1 + cy * n);
    chk(bc == 0, "R2", {tag, " count at strobe"}, bc, 0);
    chk(bw == 0, "R3", {tag, " word value and hold"}, bw, 0);
    chk(bg == 0, "R1", {tag, " cycle spacing"}, bg, 0);
    chk(bs == 0, "R1", {tag, " count step"}, bs, 0);
    repeat (4) @(negedge clk);
    chk(rd_ptr - pos0 == cy && count_o == '0 && !cyc_stb_o && !running_o, "R5",
        {tag, " halted, leftover words untouched"}, rd_ptr - pos0, cy);
  endtask

  task automatic test_reset_state();
    chk(count_o == '0 && !running_o && !cyc_stb_o && word_o == '0 && !underrun_o && !fifo_rd,
        "R8", "state in reset", count_o, 0);
  endtask

  task automatic test_idle();
    int p;
    flush();
    push(3);
    p = rd_ptr;
    repeat (4) @(negedge clk);
    chk(rd_ptr == p && !running_o && count_o == '0 && !cyc_stb_o, "R4",
        "no activity before start", rd_ptr - p, 0);
    do_start(4, 0);
    chk(running_o == 1'b0, "R4", "start with zero cycles ignored", running_o, 0);
    repeat (3) @(negedge clk);
    chk(rd_ptr == p && count_o == '0, "R4", "no read after zero-cycle start", rd_ptr - p, 0);
  endtask

  task automatic test_stall();
    int p, bad;
    flush();
    push(1);
    p = rd_ptr;
    do_start(4, 3);
    bad = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk(cyc_stb_o && count_o == 8'd3 && word_o == TAG + p, "R2", "first strobe of stall run",
            count_o, 3);
        chk(underrun_o == 1'b0, "R9", "no underrun before stall", underrun_o, 0);
      end
      if (i >= 4) begin
        if (count_o != '0 || cyc_stb_o || !running_o || fifo_rd) bad++;
      end
      if (i == 5) chk(underrun_o == 1'b1, "R9", "underrun set after stall", underrun_o, 1);
    end
    chk(bad == 0, "R6", "count frozen and no read during stall", bad, 0);
    push(2);  // at index 10
    @(negedge clk);
    chk(cyc_stb_o && count_o == 8'd3 && word_o == TAG + p + 1, "R6", "resume one clock after valid",
        word_o, TAG + p + 1);
    repeat (4) @(negedge clk);
    chk(cyc_stb_o && word_o == TAG + p + 2, "R3", "third word after resume", word_o, TAG + p + 2);
    repeat (4) @(negedge clk);
    chk(!running_o && rd_ptr - p == 3, "R5", "stall run completes", rd_ptr - p, 3);
    chk(underrun_o == 1'b1, "R9", "underrun sticky after run", underrun_o, 1);
  endtask

  task automatic test_mid_reset();
    flush();
    push(4);
    do_start(6, 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(count_o == '0 && !running_o && !cyc_stb_o && word_o == '0 && !underrun_o, "R8",
        "asynchronous reset mid-run", running_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!running_o && count_o == '0, "R8", "idle after reset release", running_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    div_i = '0;
    cycles_i = '0;
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_state();

    test_idle();
    run_plain("basic div5", 5, 5, 4, -1);
    run_plain("R7 clamp div1", 1, 2, 3, -1);
    run_plain("R7 clamp div0", 0, 2, 2, -1);
    run_plain("R4 restart ignored", 3, 3, 2, 2);
    test_stall();
    run_plain("R9 start clears underrun", 3, 3, 2, -1);
    test_mid_reset();

    finish_run();
  end

endmodule